// File: doc/BRIEF.md
# Banked GPIO Port Register File

This block is the register side of a general-purpose pin expander. It covers a number of pins set by a parameter: a power of two from 8 to 64. A host reads and writes it one byte at a time through a plain register port, which has an address, write data, a write strobe, a read strobe and registered read data. Four functional register groups are held inside: pin direction, pin level and output value, interrupt enable, and interrupt status. A fifth group is reserved.

The address map grows with the pin count. A bank shift equal to ceil(log2(N)) - 3 sets the spacing. Each group spans N/8 consecutive byte addresses, and group g starts at g shifted left by that shift. The pads appear as separate vectors for output value, output enable and input level. The input levels pass through a two-flop synchronizer. Per-pin trigger detection is done elsewhere and arrives as a pending vector. That vector sets sticky status bits. A single interrupt request line reports any status bit whose enable bit is also set.

The host port is a control interface. It has no back-pressure: a strobe is acted on in the cycle it is presented.

Top module: `gpbk_top`

## Requirements
- R1: After reset, every register is zero. pad_oe, pad_out and irq_o are 0, and every in-map read returns 0x00.
- R2: With shift S = ceil(log2(NPINS)) - 3, group g byte k sits at address (g << S) + k. The groups are 0 direction, 1 level, 2 enable, 3 status and 4 reserved. Byte k holds pins 8k to 8k+7, and pin p uses bit p mod 8.
- R3: A direction bit of 1 makes the pin an output, and 0 makes it an input. pad_oe equals the direction register, and a direction read returns the last value written.
- R4: Writing a level byte sets the output values. pad_out carries an output value only where the direction bit is 1 and is 0 on input pins.
- R5: A level read returns pad_in after a two-flop synchronizer. A read strobed in the same cycle as a pad change still returns the old level. A read strobed two cycles after the change returns the new level.
- R6: The interrupt enable bytes are writable and read back the last value written. Writing zero disables the interrupts of those pins.
- R7: A trig_pend bit sets its status bit, and that bit stays set until the host writes 1 to it at the status address. Writing 0 leaves a status bit unchanged. If a set and a clear land in the same cycle, the set wins.
- R8: irq_o is high exactly when the OR over all pins of (status AND enable) is nonzero. It reflects a status or enable change one cycle after the change is presented. A status bit whose enable bit is 0 leaves irq_o low.
- R9: The reserved group and addresses above it read as 0x00. Writes to them change no register.
- R10: host_rdata is loaded at the clock edge where host_rd is high, using the register state from before that edge. It holds its value while host_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_addr | input | AW = S+3 | Byte address |
| host_wdata | input | 8 | Write data |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 8 | Registered read data |
| pad_in | input | NPINS | Pad input levels (asynchronous) |
| pad_out | output | NPINS | Pad output values |
| pad_oe | output | NPINS | Pad output enables |
| trig_pend | input | NPINS | Pending trigger vector, one bit per pin |
| irq_o | output | 1 | Interrupt request to the host |

## Verification
The bench targets the byte that covers the upper pins. A design that ignored the bank shift would steer those writes onto pins 0 to 7. It also collides a status clear with a new pending bit on the same edge; a design that let the clear win would lose the event and never raise irq_o. Two further cases are a read strobed in the same cycle as a pad change and a write to the reserved group. A missing synchronizer stage would return the new level too early. A loose group decode would let the reserved write corrupt the direction or enable bytes. Random traffic from a fixed seed then exercises every group against a model of the registers kept in the bench.

// File: rtl/gpbk_pkg.sv
package gpbk_pkg;
  typedef enum logic [2:0] {
    GRP_DIR = 3'd0,
    GRP_LVL = 3'd1,
    GRP_IEN = 3'd2,
    GRP_IST = 3'd3,
    GRP_RSV = 3'd4
  } grp_e;

  function automatic int bank_shift(input int npins);
    return $clog2(npins) - 3;
  endfunction
endpackage

// File: rtl/gpbk_sync.sv
module gpbk_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;
endmodule

// File: rtl/gpbk_decode.sv
module gpbk_decode #(
  parameter  int NPINS = 16,
  localparam int SH    = gpbk_pkg::bank_shift(NPINS),
  localparam int AW    = SH + 3,
  localparam int NB    = NPINS / 8,
  localparam int IW    = (SH > 0) ? SH : 1
) (
  input  logic [AW-1:0] addr_i,
  output logic [2:0]    grp_o,
  output logic [IW-1:0] idx_o,
  output logic          in_map_o
);
  always_comb begin
    grp_o    = 3'(addr_i >> SH);
    idx_o    = IW'(addr_i & AW'(NB - 1));
    in_map_o = (grp_o <= 3'(gpbk_pkg::GRP_IST));
  end
endmodule

// File: rtl/gpbk_irq.sv
module gpbk_irq #(
  parameter int NPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] set_i,
  input  logic [NPINS-1:0] clr_i,
  input  logic [NPINS-1:0] en_i,
  output logic [NPINS-1:0] st_o,
  output logic             irq_o
);
  logic [NPINS-1:0] st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= (st_q & ~clr_i) | set_i;
  end

  assign st_o  = st_q;
  assign irq_o = |(st_q & en_i);

  // R7: a status bit that was not cleared stays set
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(st_q) & ~$past(clr_i)) & ~st_q) == '0));

  // R7: a pending bit always lands, even against a clear
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(set_i) & ~st_q) == '0));
endmodule

// File: rtl/gpbk_top.sv
module gpbk_top #(
  parameter  int NPINS = 16,
  localparam int SH    = gpbk_pkg::bank_shift(NPINS),
  localparam int AW    = SH + 3,
  localparam int NB    = NPINS / 8,
  localparam int IW    = (SH > 0) ? SH : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    host_addr,
  input  logic [7:0]       host_wdata,
  input  logic             host_wr,
  input  logic             host_rd,
  output logic [7:0]       host_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  input  logic [NPINS-1:0] trig_pend,
  output logic             irq_o
);
  import gpbk_pkg::*;

  logic [2:0]       grp;
  logic [IW-1:0]    idx;
  logic             in_map;
  logic [NPINS-1:0] dir_q, outv_q, en_q, st, lvl_s, clr_mask;
  logic [7:0]       rdata_q;

  gpbk_decode #(.NPINS(NPINS)) u_dec (
    .addr_i(host_addr), .grp_o(grp), .idx_o(idx), .in_map_o(in_map)
  );

  gpbk_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pad_in), .q_o(lvl_s)
  );

  for (genvar b = 0; b < NB; b++) begin : g_clr
    assign clr_mask[b*8 +: 8] =
      (host_wr && grp == 3'(GRP_IST) && idx == IW'(b)) ? host_wdata : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      outv_q <= '0;
      en_q   <= '0;
    end else if (host_wr && in_map) begin
      for (int b = 0; b < NB; b++) begin
        if (idx == IW'(b)) begin
          case (grp)
            3'(GRP_DIR): dir_q[b*8 +: 8]  <= host_wdata;
            3'(GRP_LVL): outv_q[b*8 +: 8] <= host_wdata;
            3'(GRP_IEN): en_q[b*8 +: 8]   <= host_wdata;
            default: ;
          endcase
        end
      end
    end
  end

  gpbk_irq #(.NPINS(NPINS)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_i(trig_pend), .clr_i(clr_mask),
    .en_i(en_q), .st_o(st), .irq_o(irq_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= 8'h00;
    else if (host_rd) begin
      case (grp)
        3'(GRP_DIR): rdata_q <= dir_q[8*int'(idx) +: 8];
        3'(GRP_LVL): rdata_q <= lvl_s[8*int'(idx) +: 8];
        3'(GRP_IEN): rdata_q <= en_q[8*int'(idx) +: 8];
        3'(GRP_IST): rdata_q <= st[8*int'(idx) +: 8];
        default:     rdata_q <= 8'h00;
      endcase
    end
  end

  assign host_rdata = rdata_q;
  assign pad_oe     = dir_q;
  assign pad_out    = outv_q & dir_q;

  // R10: read data holds without a read strobe
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(host_rdata));

  // R3: direction changes only through a direction write
  p_dir_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && grp == 3'(GRP_DIR)) |=> $stable(pad_oe));

  // R9: writes outside the four live groups touch no control register
  p_rsvd_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !in_map) |=> ($stable(dir_q) && $stable(outv_q) && $stable(en_q)));

  // R8: an enabled pending bit raises the request next cycle
  p_irq_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(trig_pend & en_q)) && !(host_wr && grp == 3'(GRP_IEN))) |=> irq_o);
endmodule

// File: tb/gpbk_top_tb.sv
module gpbk_top_tb;
  localparam int N  = 16;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [7:0]    host_wdata = '0;
  logic          host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]    host_rdata;
  logic [N-1:0]  pad_in = '0, pad_out, pad_oe, trig_pend = '0;
  logic          irq_o;

  int n_chk = 0, n_bad = 0;
  logic [N-1:0] m_dir = '0, m_out = '0, m_en = '0, m_st = '0, m_pin = '0;

  always #4 clk = ~clk;

  gpbk_top #(.NPINS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .trig_pend(trig_pend), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [AW-1:0] a, input logic [N-1:0] lvl);
    int g = int'(a) >> 1;
    int k = int'(a) & 1;
    case (g)
      0: return m_dir[k*8 +: 8];
      1: return lvl[k*8 +: 8];
      2: return m_en[k*8 +: 8];
      3: return m_st[k*8 +: 8];
      default: return 8'h00;
    endcase
  endfunction

  function automatic string rd_tag(input logic [AW-1:0] a);
    case (int'(a) >> 1)
      0: return "R3";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [N-1:0] put_byte(input logic [N-1:0] v, input int k, input logic [7:0] d);
    logic [N-1:0] r = v;
    r[k*8 +: 8] = d;
    return r;
  endfunction

  // One cycle of traffic; updates the model and checks the pads and irq.
  task automatic step(input logic w, input logic r, input logic [AW-1:0] a,
                      input logic [7:0] d, input logic [N-1:0] p);
    logic [7:0] e;
    logic [N-1:0] clr;
    int g, k;
    @(negedge clk);
    host_wr = w; host_rd = r; host_addr = a; host_wdata = d; trig_pend = p;
    e = exp_rd(a, m_pin);
    @(posedge clk);
    #1;
    g = int'(a) >> 1; k = int'(a) & 1;
    clr = '0;
    if (w) begin
      case (g)
        0: m_dir = put_byte(m_dir, k, d);
        1: m_out = put_byte(m_out, k, d);
        2: m_en  = put_byte(m_en, k, d);
        3: clr   = put_byte(clr, k, d);
        default: ;
      endcase
    end
    m_st = (m_st & ~clr) | p;
    if (r) check({rd_tag(a), " read"}, 32'(host_rdata), 32'(e));
    check("R3 pad_oe", 32'(pad_oe), 32'(m_dir));
    check("R4 pad_out", 32'(pad_out), 32'(m_out & m_dir));
    check("R8 irq", 32'(irq_o), 32'(|(m_st & m_en)));
  endtask

  task automatic idle();
    step(1'b0, 1'b0, '0, 8'h00, '0);
  endtask

  initial begin : watchdog
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] held;
    void'($urandom(32'd4711));
    #20; rst_n = 1'b1;
    #1;
    // R1: reset state
    check("R1 pad_oe", 32'(pad_oe), 32'h0);
    check("R1 pad_out", 32'(pad_out), 32'h0);
    check("R1 irq", 32'(irq_o), 32'h0);
    for (int a = 0; a < 8; a++) step(1'b0, 1'b1, AW'(a), 8'h00, '0);

    // R2: upper byte of direction (addr 1) covers pins 8..15; bit 7 is pin 15
    step(1'b1, 1'b0, 4'd1, 8'h80, '0);
    check("R2 pin15 oe", 32'(pad_oe), 32'h8000);
    // R2/R4: level group starts at 1<<S = 2; addr 3 bit 7 drives pin 15
    step(1'b1, 1'b0, 4'd3, 8'hFF, '0);
    check("R2 pin15 out", 32'(pad_out), 32'h8000);
    // R4: pins 8..14 have values but are inputs, so stay 0
    step(1'b1, 1'b0, 4'd1, 8'h00, '0);
    check("R4 input pins quiet", 32'(pad_out), 32'h0);

    // R8: status without enable leaves irq low
    step(1'b0, 1'b0, '0, 8'h00, 16'h0004);
    check("R8 no enable", 32'(irq_o), 32'h0);
    step(1'b1, 1'b0, 4'd4, 8'h04, '0);   // enable pin 2
    check("R8 enabled", 32'(irq_o), 32'h1);
    // R7: clear and new set on same edge: set wins
    step(1'b1, 1'b0, 4'd6, 8'h04, 16'h0004);
    check("R7 set wins", 32'(irq_o), 32'h1);
    step(1'b1, 1'b0, 4'd6, 8'h04, '0);
    check("R7 w1c", 32'(irq_o), 32'h0);
    // R7: writing 0 leaves status alone
    step(1'b0, 1'b0, '0, 8'h00, 16'h0400);
    step(1'b1, 1'b0, 4'd7, 8'h00, '0);
    step(1'b0, 1'b1, 4'd7, 8'h00, '0);
    check("R7 zero write keeps", 32'(host_rdata), 32'h04);
    // R6: disable by writing zero
    step(1'b1, 1'b0, 4'd4, 8'h00, '0);
    check("R6 disabled", 32'(irq_o), 32'h0);

    // R9: reserved and out-of-map writes change nothing
    step(1'b1, 1'b0, 4'd8, 8'hFF, '0);
    step(1'b1, 1'b0, 4'd9, 8'hFF, '0);
    step(1'b1, 1'b0, 4'd12, 8'hFF, '0);
    step(1'b0, 1'b1, 4'd8, 8'h00, '0);
    check("R9 rsv read", 32'(host_rdata), 32'h0);
    step(1'b0, 1'b1, 4'd0, 8'h00, '0);
    check("R9 dir untouched", 32'(host_rdata), 32'h0);

    // R5: synchronizer latency
    @(negedge clk);
    pad_in = 16'h5A3C;
    host_rd = 1'b1; host_addr = 4'd2; host_wr = 1'b0; trig_pend = '0;
    @(posedge clk); #1;
    check("R5 old level", 32'(host_rdata), 32'h00);
    @(negedge clk); host_rd = 1'b0;
    @(negedge clk); host_rd = 1'b1;
    @(posedge clk); #1;
    check("R5 new level", 32'(host_rdata), 32'h3C);
    m_pin = pad_in;
    // R10: rdata holds with rd low and a new address
    held = host_rdata;
    step(1'b0, 1'b0, 4'd3, 8'h00, '0);
    check("R10 hold", 32'(host_rdata), 32'(held));

    // random traffic
    for (int i = 0; i < 600; i++) begin
      logic [3:0] op;
      logic [AW-1:0] a;
      logic [N-1:0] p;
      if (i % 60 == 0) begin
        @(negedge clk); pad_in = N'($urandom);
        idle(); idle(); idle();
        m_pin = pad_in;
      end
      op = 4'($urandom);
      a  = AW'($urandom);
      p  = (op[3:2] == 2'b00) ? (N'(1) << ($urandom % N)) : '0;
      step(op[0], !op[0] && op[1], a, 8'($urandom), p);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule